// File: doc/BRIEF.md
# Doorbell Scratch Register Interrupt Trigger

This block holds two 32-bit configuration registers that software reaches through a simple dword-addressed write/read port with per-byte enables. Selected bytes of each register are doorbells: a write to any of them stores the data like plain storage and also raises a display event interrupt toward the interrupt logic. A byte, word or doubleword write that lands on several doorbell bytes at once still produces one interrupt.

The first register, the system event register, has three doorbell bytes. The second register, the legacy brightness register, has one doorbell byte beside a plain storage byte. Each register's trigger passes through its own qualifying chain before the two merge into one event. The shared qualifiers are the enable bit and the mask bit of the interrupt controller. The brightness trigger also needs a pipe-status event enable. The result is a one-cycle interrupt pulse and a sticky status bit that a separate clear input resets.

Top module: `dbl_doorbell_trig`

## Requirements
- R1: After a synchronous active-high reset, both registers read 00000000h and `irq_pulse` and `irq_sticky` are 0.
- R2: The system event register is at dword address 39h (byte offset E4h) and the brightness register at 3Dh (F4h). A write sets only the bytes whose `cfg_be` bit is 1, where bit n covers data bits 8n+7:8n. `cfg_rdata` returns the addressed register in the same cycle and returns 0 for any other address.
- R3: Reserved bytes ignore writes and read as zero: byte 3 of the event register, and bytes 1 and 2 of the brightness register.
- R4: A write to the event register with any of bytes 0, 1 or 2 enabled, while `irq_en_bit`=1 and `irq_mask_bit`=0, sets `irq_pulse` high for exactly the cycle after the write edge.
- R5: A write that enables several doorbell bytes produces one single-cycle pulse, not one per byte.
- R6: No pulse is raised while `irq_en_bit`=0 or `irq_mask_bit`=1, for either register.
- R7: A write with byte 3 of the brightness register enabled pulses only when `pipe_evt_en`=1, `irq_en_bit`=1 and `irq_mask_bit`=0.
- R8: A write with all byte enables low, or one that touches only non-doorbell bytes (event byte 3, brightness bytes 0 to 2), raises no pulse. Brightness byte 0 is still stored.
- R9: `irq_sticky` is set with every pulse and holds until `sticky_clr` is 1 in a cycle without a new pulse. A pulse in the same cycle as the clear leaves it set.
- R10: A write to any other address changes neither register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 6 | Dword address of the access |
| cfg_wr | input | 1 | Write strobe, one write per cycle |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed register |
| irq_en_bit | input | 1 | Display event enable bit of the interrupt enable register |
| irq_mask_bit | input | 1 | Display event bit of the interrupt mask register (1 = masked) |
| pipe_evt_en | input | 1 | Brightness event enable from the pipe status register |
| sticky_clr | input | 1 | Clears the sticky status bit |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_sticky | output | 1 | Sticky interrupt status |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `irq_en_bit` and `irq_mask_bit` are sampled at the same edge as the write they qualify, so a pulse can be traced to the qualifier values one cycle earlier. The bench holds reset over the opening edges. It changes every input only on the falling edge and keeps the qualifiers steady across each write edge. It also leaves `cfg_wr` low between the vectors, so every pulse can be traced to one write.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int unsigned BYTES  = 4;
  localparam int unsigned DATA_W = 8 * BYTES;

  // True when the write enables reach at least one doorbell byte.
  function automatic logic touches_doorbell(input logic [BYTES-1:0] be,
                                            input logic [BYTES-1:0] trig_mask);
    return |(be & trig_mask);
  endfunction

  // Interrupt qualification: enabled, not masked, and source-side enable.
  function automatic logic qualify(input logic en_bit, input logic mask_bit,
                                   input logic src_en);
    return en_bit & ~mask_bit & src_en;
  endfunction
endpackage

// File: rtl/dbl_regbank.sv
module dbl_regbank
  import dbl_pkg::*;
#(
  parameter logic [BYTES-1:0] TRIG_MASK = '0,
  parameter logic [BYTES-1:0] RSVD_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [BYTES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              trig_hit
);
  logic wr_hit;
  assign wr_hit   = sel & wr;
  assign trig_hit = wr_hit & touches_doorbell(be, TRIG_MASK);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    if (RSVD_MASK[b]) begin : g_rsvd
      assign q[8*b +: 8] = 8'h00;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)
          q[8*b +: 8] <= 8'h00;
        else if (wr_hit && be[b])
          q[8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/dbl_trig_gate.sv
module dbl_trig_gate
  import dbl_pkg::*;
(
  input  logic hit,
  input  logic en_bit,
  input  logic mask_bit,
  input  logic src_en,
  output logic fire
);
  assign fire = hit & qualify(en_bit, mask_bit, src_en);
endmodule

// File: rtl/dbl_irq_out.sv
module dbl_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic fire_any,
  input  logic clr,
  output logic pulse,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
    end else begin
      pulse <= fire_any;
      if (fire_any)
        sticky <= 1'b1;
      else if (clr)
        sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/dbl_doorbell_trig.sv
module dbl_doorbell_trig
  import dbl_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 6'h39,
  parameter logic [ADDR_W-1:0] BRT_ADDR = 6'h3D,
  parameter logic [BYTES-1:0]  EVT_TRIG = 4'b0111,
  parameter logic [BYTES-1:0]  EVT_RSVD = 4'b1000,
  parameter logic [BYTES-1:0]  BRT_TRIG = 4'b1000,
  parameter logic [BYTES-1:0]  BRT_RSVD = 4'b0110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [BYTES-1:0]  cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              irq_en_bit,
  input  logic              irq_mask_bit,
  input  logic              pipe_evt_en,
  input  logic              sticky_clr,
  output logic              irq_pulse,
  output logic              irq_sticky
);
  // Named internal events, visible to the bound checker.
  logic              evt_sel, brt_sel;
  logic              evt_hit, brt_hit;
  logic              evt_fire, brt_fire, fire_any;
  logic [DATA_W-1:0] evt_q, brt_q;

  assign evt_sel = (cfg_addr == EVT_ADDR);
  assign brt_sel = (cfg_addr == BRT_ADDR);

  dbl_regbank #(.TRIG_MASK(EVT_TRIG), .RSVD_MASK(EVT_RSVD)) u_evt_reg (
    .clk(clk), .rst(rst), .sel(evt_sel), .wr(cfg_wr), .be(cfg_be),
    .wdata(cfg_wdata), .q(evt_q), .trig_hit(evt_hit)
  );

  dbl_regbank #(.TRIG_MASK(BRT_TRIG), .RSVD_MASK(BRT_RSVD)) u_brt_reg (
    .clk(clk), .rst(rst), .sel(brt_sel), .wr(cfg_wr), .be(cfg_be),
    .wdata(cfg_wdata), .q(brt_q), .trig_hit(brt_hit)
  );

  dbl_trig_gate u_evt_gate (
    .hit(evt_hit), .en_bit(irq_en_bit), .mask_bit(irq_mask_bit),
    .src_en(1'b1), .fire(evt_fire)
  );

  dbl_trig_gate u_brt_gate (
    .hit(brt_hit), .en_bit(irq_en_bit), .mask_bit(irq_mask_bit),
    .src_en(pipe_evt_en), .fire(brt_fire)
  );

  assign fire_any = evt_fire | brt_fire;

  dbl_irq_out u_irq (
    .clk(clk), .rst(rst), .fire_any(fire_any), .clr(sticky_clr),
    .pulse(irq_pulse), .sticky(irq_sticky)
  );

  always_comb begin
    if (evt_sel)      cfg_rdata = evt_q;
    else if (brt_sel) cfg_rdata = brt_q;
    else              cfg_rdata = '0;
  end
endmodule

// File: rtl/dbl_doorbell_chk.sv
module dbl_doorbell_chk
  import dbl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              evt_sel,
  input logic              brt_sel,
  input logic              irq_en_bit,
  input logic              irq_mask_bit,
  input logic              sticky_clr,
  input logic              evt_fire,
  input logic              brt_fire,
  input logic              irq_pulse,
  input logic              irq_sticky,
  input logic [DATA_W-1:0] evt_q,
  input logic [DATA_W-1:0] brt_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq_pulse && !irq_sticky));

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(evt_q) && $stable(brt_q)));

  // R10
  unmapped_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !evt_sel && !brt_sel) |=> ($stable(evt_q) && $stable(brt_q) && !irq_pulse));

  // R5
  single_source_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_fire, brt_fire}));

  // R6
  qualified_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_en_bit && !irq_mask_bit));

  // R8
  pulse_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(cfg_wr));

  // R9
  sticky_follows_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_sticky);

  // R9
  sticky_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_sticky) |-> $past(sticky_clr));
endmodule

bind dbl_doorbell_trig dbl_doorbell_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .evt_sel(evt_sel), .brt_sel(brt_sel),
  .irq_en_bit(irq_en_bit), .irq_mask_bit(irq_mask_bit), .sticky_clr(sticky_clr),
  .evt_fire(evt_fire), .brt_fire(brt_fire), .irq_pulse(irq_pulse),
  .irq_sticky(irq_sticky), .evt_q(evt_q), .brt_q(brt_q)
);

// File: tb/dbl_doorbell_trig_bench.sv
module dbl_doorbell_trig_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 19;
  // entry: {addr[5:0], be[3:0], en, mask, pipe, expected_pulse}
  localparam logic [13:0] VEC [NV] = '{
    {6'h39, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 byte 0
    {6'h39, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 byte 1
    {6'h39, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 byte 2
    {6'h39, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 reserved only
    {6'h39, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 dword
    {6'h39, 4'b0011, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 word
    {6'h39, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 no enables
    {6'h39, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 disabled
    {6'h39, 4'b0111, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 masked
    {6'h3D, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b1},  // R7 all qualified
    {6'h3D, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 pipe off
    {6'h3D, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0},  // R7 disabled
    {6'h3D, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 masked
    {6'h3D, 4'b0001, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 level byte
    {6'h3D, 4'b0110, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 reserved bytes
    {6'h3D, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 dword
    {6'h20, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b0},  // R10 unmapped
    {6'h3A, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0},  // R10 neighbour
    {6'h3D, 4'b1001, 1'b1, 1'b0, 1'b0, 1'b0}   // R7 pipe off, level stored
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_en_bit = 1'b0, irq_mask_bit = 1'b0, pipe_evt_en = 1'b0;
  logic        sticky_clr = 1'b0;
  logic        irq_pulse, irq_sticky;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] evt_m = '0, brt_m = '0;

  always #(CLK_P/2) clk = ~clk;

  dbl_doorbell_trig u_dbl_doorbell_trig (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_en_bit(irq_en_bit),
    .irq_mask_bit(irq_mask_bit), .pipe_evt_en(pipe_evt_en), .sticky_clr(sticky_clr),
    .irq_pulse(irq_pulse), .irq_sticky(irq_sticky)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Independent model of storage: event keeps bytes 0-2, brightness bytes 0 and 3.
  task automatic model_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      if (be[b] && a == 6'h39 && b != 3) evt_m[8*b +: 8] = d[8*b +: 8];
      if (be[b] && a == 6'h3D && (b == 0 || b == 3)) brt_m[8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  // Drive at a falling edge; the write is taken at the next rising edge.
  task automatic do_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pulse", {31'b0, irq_pulse}, 32'h0);
    chk("R1 sticky", {31'b0, irq_sticky}, 32'h0);
    read_chk("R1 evt", 6'h39, 32'h0);
    read_chk("R1 brt", 6'h3D, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [5:0]  a;
      logic [3:0]  be;
      logic [31:0] d;
      a  = VEC[i][13:8];
      be = VEC[i][7:4];
      d  = {4{8'(i * 37 + 5)}} ^ 32'h5A3C_0F96;
      irq_en_bit = VEC[i][3]; irq_mask_bit = VEC[i][2]; pipe_evt_en = VEC[i][1];
      do_write(a, be, d);
      model_write(a, be, d);
      chk($sformatf("R4/R6/R7/R8/R10 pulse vec%0d", i), {31'b0, irq_pulse}, {31'b0, VEC[i][0]});
      @(negedge clk);
      chk($sformatf("R5 single cycle vec%0d", i), {31'b0, irq_pulse}, 32'h0);
      read_chk($sformatf("R2/R3 evt vec%0d", i), 6'h39, evt_m);
      read_chk($sformatf("R2/R3 brt vec%0d", i), 6'h3D, brt_m);
    end

    // R2 other addresses read zero
    read_chk("R2 unmapped read", 6'h00, 32'h0);

    // R9 sticky holds, clears, and set wins over clear
    chk("R9 sticky held", {31'b0, irq_sticky}, 32'h1);
    @(negedge clk);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    chk("R9 sticky cleared", {31'b0, irq_sticky}, 32'h0);
    irq_en_bit = 1'b1; irq_mask_bit = 1'b0;
    sticky_clr = 1'b1;
    do_write(6'h39, 4'b0100, 32'h00AB_0000);
    model_write(6'h39, 4'b0100, 32'h00AB_0000);
    sticky_clr = 1'b0;
    chk("R9 set wins pulse", {31'b0, irq_pulse}, 32'h1);
    chk("R9 set wins sticky", {31'b0, irq_sticky}, 32'h1);
    read_chk("R2 byte 2 only", 6'h39, evt_m);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 sticky after reset", {31'b0, irq_sticky}, 32'h0);
    read_chk("R1 evt after reset", 6'h39, 32'h0);
    read_chk("R1 brt after reset", 6'h3D, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule